// File: doc/BRIEF.md
# Split Completion Tag Tracker

The block keeps a table of outstanding non-posted read requests, one entry per tag. Each entry holds the requester ID, traffic class and attributes of the request. It also holds the byte address of the next byte still owed and the number of bytes still owed. Each completion header that arrives on a one-cycle strobe is graded against its tag's entry. The result is a 96-bit completion descriptor with a four-bit error code and a request-finished flag, and the block moves the entry forward or frees it.

Requests are registered through an issue port. Timeout and function-reset notices for a tag arrive on a side port and produce their own descriptors. Descriptors queue in a small buffer and leave on a valid/ready handshake. A room signal tells the upstream logic when it may strobe. The block does not move payload data, does not parse TLPs and does not time requests out by itself.

Top module: `cpl_tracker`

## Requirements
- R1: Descriptor bit layout: [11:0] lower byte address, [15:12] error code, [28:16] byte count, [29] locked, [30] request finished, [42:32] dword count, [45:43] completion status, [46] poisoned, [63:48] requester ID, [71:64] tag (zero-extended), [87:72] completer ID, [91:89] traffic class, [94:92] attributes. Bits 31, 47, 88 and 95 are always 0.
- R2: Bytes returned = min(byte count, 4*dword count - laddr[1:0]). A clean completion whose returned bytes reach its byte count gives code 0000 with bit 30 set. The lower address field is the stored next address, and locked, status, poison, IDs, class and attributes are copied from the header.
- R3: A clean completion that returns fewer bytes than its byte count gives code 0000 with bit 30 clear. The stored next address advances by the returned bytes modulo 4096, and the stored remaining count becomes byte count minus returned bytes. Back-to-back strobes on one tag see the updated values.
- R4: Code 0001 when the header is poisoned. Code 0010 when the status is not 000, where status 000 = success, 001 = UR, 010 = CRS and 100 = CA.
- R5: Code 0011 when the dword count is 0 or the byte count exceeds the stored remaining count.
- R6: Code 0100 when the requester ID, traffic class or attributes differ from the stored request.
- R7: Code 0101 when laddr[6:0] differs from bits [6:0] of the stored next address.
- R8: Code 0110 for a tag with no live entry. Bit 30 is clear and the lower address field is {5'b0, laddr}.
- R9: When several codes apply, the lowest one is reported. Codes 0001 and 0010 apply even to unknown tags.
- R10: A code from 0001 to 0101 on a live tag sets bit 30 and frees the entry, so a later strobe on that tag gets code 0110.
- R11: A side-port event (kind 0 = timeout, kind 1 = function reset) on a live tag gives code 1001 or 1000 respectively. The descriptor has bit 30 set, requester ID field {8'h00, stored ID[7:0]}, the tag, and every other field 0, and the entry is freed. An event on a tag with no live entry produces nothing.
- R12: After reset no descriptor is pending. A descriptor becomes valid two clock edges after its strobe, and it holds valid and stable until accepted by ready.
- R13: cpl_room is low while FIFO_DEPTH descriptors are queued or in flight, and a strobe while it is low is ignored. ev_ready = cpl_room and not cpl_valid, and an event while ev_ready is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Register a request this cycle |
| iss_tag | input | TAG_W | Tag of the new request |
| iss_rid | input | 16 | Requester ID of the request |
| iss_tc | input | 3 | Traffic class of the request |
| iss_attr | input | 3 | Attributes of the request |
| iss_addr | input | 12 | Low 12 bits of the first byte address |
| iss_len | input | 13 | Request length in bytes (1 to 4096) |
| cpl_valid | input | 1 | Completion header strobe |
| cpl_room | output | 1 | A strobe this cycle will be taken |
| cpl_tag | input | TAG_W | Completion tag |
| cpl_rid | input | 16 | Requester ID in the header |
| cpl_cplid | input | 16 | Completer ID in the header |
| cpl_tc | input | 3 | Traffic class in the header |
| cpl_attr | input | 3 | Attributes in the header |
| cpl_status | input | 3 | Completion status |
| cpl_poison | input | 1 | Poisoned header |
| cpl_locked | input | 1 | Locked read completion |
| cpl_laddr | input | 7 | Lower address in the header |
| cpl_bcnt | input | 13 | Byte count in the header |
| cpl_dwcnt | input | 11 | Payload length in dwords |
| ev_valid | input | 1 | Timeout or function-reset event |
| ev_ready | output | 1 | The event is taken this cycle |
| ev_kind | input | 1 | 0 = timeout, 1 = function reset |
| ev_tag | input | TAG_W | Tag of the event |
| dsc_valid | output | 1 | Descriptor available |
| dsc_ready | input | 1 | Descriptor accepted |
| dsc_data | output | 96 | Completion descriptor |

## Verification
The bench splits one request into two completions, with the stored address wrapping past 4095. A tracker that did not carry the address modulo 4096 would flag code 0101 on the second part. Two strobes in consecutive cycles on one tag catch an update that lands too late, which would grade the second strobe against stale state. Headers with several faults at once expose a wrong priority order. Strobes after an error or an event show whether the entry was really freed, since a leaked entry yields 0000 instead of 0110. A burst against a stalled consumer shows whether the room signal drops in time, because an overrun loses or duplicates descriptors.

// File: rtl/cpl_tracker_pkg.sv
package cpl_tracker_pkg;
  localparam int RID_W  = 16;
  localparam int ADDR_W = 12;
  localparam int BC_W   = 13;
  localparam int DWC_W  = 11;
  localparam int LA_W   = 7;
  localparam int DSC_W  = 96;

  localparam logic [3:0] EC_OK       = 4'b0000;
  localparam logic [3:0] EC_POISON   = 4'b0001;
  localparam logic [3:0] EC_STATUS   = 4'b0010;
  localparam logic [3:0] EC_COUNT    = 4'b0011;
  localparam logic [3:0] EC_MISMATCH = 4'b0100;
  localparam logic [3:0] EC_ADDR     = 4'b0101;
  localparam logic [3:0] EC_NOTAG    = 4'b0110;
  localparam logic [3:0] EC_FNRESET  = 4'b1000;
  localparam logic [3:0] EC_TIMEOUT  = 4'b1001;

  // Request context kept in block RAM (written only at issue time)
  typedef struct packed {
    logic [RID_W-1:0] rid;
    logic [2:0]       tc;
    logic [2:0]       attr;
  } req_ctx_t;

  // Per-tag progress kept in registers (updated by each completion)
  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BC_W-1:0]   left;
  } req_prog_t;

  typedef struct packed {
    logic [RID_W-1:0] rid;
    logic [RID_W-1:0] cplid;
    logic [2:0]       tc;
    logic [2:0]       attr;
    logic [2:0]       status;
    logic             poison;
    logic             locked;
    logic [LA_W-1:0]  laddr;
    logic [BC_W-1:0]  bcnt;
    logic [DWC_W-1:0] dwcnt;
  } cpl_hdr_t;

  function automatic logic [DSC_W-1:0] pack_dsc(
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        ec,
    input logic [BC_W-1:0]   bc,
    input logic              locked,
    input logic              done,
    input logic [DWC_W-1:0]  dw,
    input logic [2:0]        st,
    input logic              poison,
    input logic [RID_W-1:0]  rid,
    input logic [7:0]        tag,
    input logic [RID_W-1:0]  cplid,
    input logic [2:0]        tc,
    input logic [2:0]        attr);
    logic [DSC_W-1:0] d;
    d = '0;
    d[11:0]  = addr;
    d[15:12] = ec;
    d[28:16] = bc;
    d[29]    = locked;
    d[30]    = done;
    d[42:32] = dw;
    d[45:43] = st;
    d[46]    = poison;
    d[63:48] = rid;
    d[71:64] = tag;
    d[87:72] = cplid;
    d[91:89] = tc;
    d[94:92] = attr;
    return d;
  endfunction
endpackage

// File: rtl/cpl_ctx_ram.sv
module cpl_ctx_ram #(
  parameter int AW = 8,
  parameter int DW = 22
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cpl_grader.sv
module cpl_grader
  import cpl_tracker_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             is_event,
  input  logic             ev_kind,
  input  logic             live,
  input  logic [TAG_W-1:0] tag,
  input  req_ctx_t         ctx,
  input  req_prog_t        prog,
  input  cpl_hdr_t         hdr,
  output logic             emit,
  output logic             release_tag,
  output logic             advance,
  output req_prog_t        next_prog,
  output logic [DSC_W-1:0] dsc
);
  logic [7:0]      tag8;
  logic [BC_W-1:0] avail;
  logic [BC_W-1:0] ret;
  logic            last;
  logic            f_count, f_mis, f_addr;
  logic [3:0]      ec;
  logic            done;
  logic [ADDR_W-1:0] low;

  always_comb begin
    tag8 = '0;
    tag8[TAG_W-1:0] = tag;
  end

  assign avail   = {hdr.dwcnt, 2'b00} - {{(BC_W-2){1'b0}}, hdr.laddr[1:0]};
  assign last    = (avail >= hdr.bcnt);
  assign ret     = last ? hdr.bcnt : avail;
  assign f_count = (hdr.dwcnt == '0) || (hdr.bcnt > prog.left);
  assign f_mis   = (hdr.rid != ctx.rid) || (hdr.tc != ctx.tc) || (hdr.attr != ctx.attr);
  assign f_addr  = (hdr.laddr != prog.addr[LA_W-1:0]);

  always_comb begin
    if (hdr.poison)               ec = EC_POISON;
    else if (hdr.status != 3'b0)  ec = EC_STATUS;
    else if (!live)               ec = EC_NOTAG;
    else if (f_count)             ec = EC_COUNT;
    else if (f_mis)               ec = EC_MISMATCH;
    else if (f_addr)              ec = EC_ADDR;
    else                          ec = EC_OK;
  end

  assign done = live && ((ec != EC_OK) || last);
  assign low  = live ? prog.addr : {{(ADDR_W-LA_W){1'b0}}, hdr.laddr};

  always_comb begin
    next_prog.addr = prog.addr + ret[ADDR_W-1:0];
    next_prog.left = hdr.bcnt - ret;
    if (is_event) begin
      emit        = live;
      release_tag = live;
      advance     = 1'b0;
      dsc = pack_dsc('0, ev_kind ? EC_FNRESET : EC_TIMEOUT, '0, 1'b0, 1'b1,
                     '0, 3'b0, 1'b0, {8'h00, ctx.rid[7:0]}, tag8, '0, 3'b0, 3'b0);
    end else begin
      emit        = 1'b1;
      release_tag = done;
      advance     = live && (ec == EC_OK) && !last;
      dsc = pack_dsc(low, ec, hdr.bcnt, hdr.locked, done, hdr.dwcnt, hdr.status,
                     hdr.poison, hdr.rid, tag8, hdr.cplid, hdr.tc, hdr.attr);
    end
  end
endmodule

// File: rtl/cpl_dsc_fifo.sv
module cpl_dsc_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 96
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [W-1:0]   pdata,
  input  logic           pop,
  output logic           out_valid,
  output logic [W-1:0]   out_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_pop;

  assign out_valid = (count != '0);
  assign out_data  = mem[rp];
  assign do_pop    = pop && out_valid;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push)   wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/cpl_tracker.sv
module cpl_tracker
  import cpl_tracker_pkg::*;
#(
  parameter int TAG_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [15:0]       iss_rid,
  input  logic [2:0]        iss_tc,
  input  logic [2:0]        iss_attr,
  input  logic [11:0]       iss_addr,
  input  logic [12:0]       iss_len,
  input  logic              cpl_valid,
  output logic              cpl_room,
  input  logic [TAG_W-1:0]  cpl_tag,
  input  logic [15:0]       cpl_rid,
  input  logic [15:0]       cpl_cplid,
  input  logic [2:0]        cpl_tc,
  input  logic [2:0]        cpl_attr,
  input  logic [2:0]        cpl_status,
  input  logic              cpl_poison,
  input  logic              cpl_locked,
  input  logic [6:0]        cpl_laddr,
  input  logic [12:0]       cpl_bcnt,
  input  logic [10:0]       cpl_dwcnt,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_kind,
  input  logic [TAG_W-1:0]  ev_tag,
  output logic              dsc_valid,
  input  logic              dsc_ready,
  output logic [95:0]       dsc_data
);
  localparam int NTAGS = 1 << TAG_W;
  localparam int CTX_W = $bits(req_ctx_t);
  localparam int CW    = $clog2(FIFO_DEPTH+1);

  // stage 0: accept
  logic             take_cpl, take_ev;
  logic [TAG_W-1:0] rd_tag;
  req_ctx_t         iss_ctx;
  cpl_hdr_t         in_hdr;

  // stage 1: grade
  logic             s1_vld, s1_ev, s1_kind;
  logic [TAG_W-1:0] s1_tag;
  cpl_hdr_t         s1_hdr;
  req_ctx_t         s1_ctx;
  logic [CTX_W-1:0] ctx_raw;

  // table
  logic [NTAGS-1:0] live_q;
  req_prog_t        prog_q [NTAGS];

  // grader results
  logic             g_emit, g_rel, g_adv;
  req_prog_t        g_next;
  logic [DSC_W-1:0] g_dsc;

  logic [CW-1:0]    q_count;

  assign cpl_room = ({1'b0, q_count} + (CW+1)'(s1_vld)) < (CW+1)'(FIFO_DEPTH);
  assign ev_ready = cpl_room && !cpl_valid;
  assign take_cpl = cpl_valid && cpl_room;
  assign take_ev  = ev_valid && ev_ready;
  assign rd_tag   = cpl_valid ? cpl_tag : ev_tag;

  assign iss_ctx = '{rid: iss_rid, tc: iss_tc, attr: iss_attr};

  assign in_hdr = '{rid: cpl_rid, cplid: cpl_cplid, tc: cpl_tc, attr: cpl_attr,
                    status: cpl_status, poison: cpl_poison, locked: cpl_locked,
                    laddr: cpl_laddr, bcnt: cpl_bcnt, dwcnt: cpl_dwcnt};

  cpl_ctx_ram #(.AW(TAG_W), .DW(CTX_W)) u_ctx (
    .clk   (clk),
    .we    (iss_valid),
    .waddr (iss_tag),
    .wdata (iss_ctx),
    .raddr (rd_tag),
    .rdata (ctx_raw)
  );
  assign s1_ctx = req_ctx_t'(ctx_raw);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= take_cpl || take_ev;
    end
    s1_ev   <= !cpl_valid;
    s1_kind <= ev_kind;
    s1_tag  <= rd_tag;
    s1_hdr  <= in_hdr;
  end

  cpl_grader #(.TAG_W(TAG_W)) u_grade (
    .is_event    (s1_ev),
    .ev_kind     (s1_kind),
    .live        (live_q[s1_tag]),
    .tag         (s1_tag),
    .ctx         (s1_ctx),
    .prog        (prog_q[s1_tag]),
    .hdr         (s1_hdr),
    .emit        (g_emit),
    .release_tag (g_rel),
    .advance     (g_adv),
    .next_prog   (g_next),
    .dsc         (g_dsc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else begin
      if (s1_vld && g_rel) live_q[s1_tag] <= 1'b0;
      if (iss_valid)       live_q[iss_tag] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_vld && g_adv) prog_q[s1_tag] <= g_next;
    if (iss_valid)       prog_q[iss_tag] <= '{addr: iss_addr, left: iss_len};
  end

  cpl_dsc_fifo #(.DEPTH(FIFO_DEPTH), .W(DSC_W)) u_q (
    .clk       (clk),
    .rst       (rst),
    .push      (s1_vld && g_emit),
    .pdata     (g_dsc),
    .pop       (dsc_ready),
    .out_valid (dsc_valid),
    .out_data  (dsc_data),
    .count     (q_count)
  );
endmodule

// File: rtl/cpl_tracker_chk.sv
module cpl_tracker_chk (
  input logic        clk,
  input logic        rst,
  input logic        dsc_valid,
  input logic        dsc_ready,
  input logic [95:0] dsc_data
);
  logic [3:0] ec;
  assign ec = dsc_data[15:12];

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    dsc_valid && !dsc_ready |=> dsc_valid && $stable(dsc_data));

  p_reserved_r1: assert property (@(posedge clk) disable iff (rst)
    dsc_valid |-> !dsc_data[31] && !dsc_data[47] && !dsc_data[88] && !dsc_data[95]);

  p_err_done_r10: assert property (@(posedge clk) disable iff (rst)
    dsc_valid && (ec == 4'd3 || ec == 4'd4 || ec == 4'd5) |-> dsc_data[30]);

  p_notag_open_r8: assert property (@(posedge clk) disable iff (rst)
    dsc_valid && ec == 4'd6 |-> !dsc_data[30]);

  p_event_shape_r11: assert property (@(posedge clk) disable iff (rst)
    dsc_valid && (ec == 4'd8 || ec == 4'd9) |->
      dsc_data[30] && dsc_data[42:32] == 11'd0 && dsc_data[28:16] == 13'd0);

  p_clean_r2: assert property (@(posedge clk) disable iff (rst)
    dsc_valid && ec == 4'd0 |->
      dsc_data[45:43] == 3'd0 && !dsc_data[46] && dsc_data[42:32] != 11'd0);
endmodule

bind cpl_tracker cpl_tracker_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .dsc_valid (dsc_valid),
  .dsc_ready (dsc_ready),
  .dsc_data  (dsc_data)
);

// File: tb/sim_cpl_tracker.sv
`timescale 1ns/1ps
module sim_cpl_tracker;
  localparam time CLK_P = 20ns;
  localparam logic [15:0] RID   = 16'h0123;
  localparam logic [15:0] CPLID = 16'h0A10;

  logic        clk = 1'b0;
  logic        rst;
  logic        iss_valid;
  logic [7:0]  iss_tag;
  logic [15:0] iss_rid;
  logic [2:0]  iss_tc, iss_attr;
  logic [11:0] iss_addr;
  logic [12:0] iss_len;
  logic        cpl_valid, cpl_room;
  logic [7:0]  cpl_tag;
  logic [15:0] cpl_rid, cpl_cplid;
  logic [2:0]  cpl_tc, cpl_attr, cpl_status;
  logic        cpl_poison, cpl_locked;
  logic [6:0]  cpl_laddr;
  logic [12:0] cpl_bcnt;
  logic [10:0] cpl_dwcnt;
  logic        ev_valid, ev_ready, ev_kind;
  logic [7:0]  ev_tag;
  logic        dsc_valid, dsc_ready;
  logic [95:0] dsc_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  cpl_tracker u0 (.*);

  function automatic logic [95:0] mk(input logic [11:0] a, input logic [3:0] ec,
      input logic [12:0] bc, input logic lk, input logic dn, input logic [10:0] dw,
      input logic [2:0] st, input logic pz, input logic [15:0] rid, input logic [7:0] tg,
      input logic [15:0] cid, input logic [2:0] tc, input logic [2:0] at);
    logic [95:0] d = '0;
    d[11:0] = a; d[15:12] = ec; d[28:16] = bc; d[29] = lk; d[30] = dn;
    d[42:32] = dw; d[45:43] = st; d[46] = pz; d[63:48] = rid; d[71:64] = tg;
    d[87:72] = cid; d[91:89] = tc; d[94:92] = at;
    return d;
  endfunction

  task automatic chk(input string req, input logic [95:0] got, input logic [95:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input [7:0] tg, input [15:0] rid, input [11:0] a, input [12:0] len);
    iss_valid = 1; iss_tag = tg; iss_rid = rid; iss_tc = 0; iss_attr = 0;
    iss_addr = a; iss_len = len;
    @(negedge clk); iss_valid = 0;
  endtask

  task automatic drive_cpl(input [7:0] tg, input [15:0] rid, input [2:0] at, input [2:0] st,
      input pz, input lk, input [6:0] la, input [12:0] bc, input [10:0] dw);
    cpl_valid = 1; cpl_tag = tg; cpl_rid = rid; cpl_cplid = CPLID; cpl_tc = 0;
    cpl_attr = at; cpl_status = st; cpl_poison = pz; cpl_locked = lk;
    cpl_laddr = la; cpl_bcnt = bc; cpl_dwcnt = dw;
  endtask

  task automatic send(input [7:0] tg, input [15:0] rid, input [2:0] at, input [2:0] st,
      input pz, input lk, input [6:0] la, input [12:0] bc, input [10:0] dw);
    drive_cpl(tg, rid, at, st, pz, lk, la, bc, dw);
    @(negedge clk); cpl_valid = 0;
  endtask

  task automatic take(input string req, input logic [95:0] exp);
    bit got = 0;
    for (int i = 0; i < 20 && !got; i++) begin
      if (dsc_valid) got = 1; else @(negedge clk);
    end
    if (!got) begin
      checks++; fails++;
      $display("FAIL %s: got no descriptor expected %h", req, exp);
    end else begin
      chk(req, dsc_data, exp);
      dsc_ready = 1; @(negedge clk); dsc_ready = 0;
    end
  endtask

  task automatic expect_quiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, {95'b0, dsc_valid}, 96'b0);
    end
  endtask

  task automatic t_reset;
    chk("R12 reset valid", {95'b0, dsc_valid}, 96'b0);
    chk("R13 reset room", {94'b0, cpl_room, ev_ready}, 96'd3);
  endtask

  task automatic t_full;
    issue(8'd5, RID, 12'h100, 13'd16);
    send(8'd5, RID, 0, 0, 0, 0, 7'h00, 13'd16, 11'd4);
    take("R2 full", mk(12'h100, 0, 16, 0, 1, 4, 0, 0, RID, 5, CPLID, 0, 0));
    send(8'd5, RID, 0, 0, 0, 0, 7'h00, 13'd16, 11'd4);
    take("R10 freed after done", mk(12'h000, 6, 16, 0, 0, 4, 0, 0, RID, 5, CPLID, 0, 0));
    issue(8'd9, RID, 12'h102, 13'd6);
    send(8'd9, RID, 0, 0, 0, 1, 7'h02, 13'd6, 11'd2);
    take("R2 unaligned locked", mk(12'h102, 0, 6, 1, 1, 2, 0, 0, RID, 9, CPLID, 0, 0));
  endtask

  task automatic t_split_wrap;
    issue(8'd7, RID, 12'hFF8, 13'd24);
    send(8'd7, RID, 0, 0, 0, 0, 7'h78, 13'd24, 11'd2);
    take("R3 first part", mk(12'hFF8, 0, 24, 0, 0, 2, 0, 0, RID, 7, CPLID, 0, 0));
    send(8'd7, RID, 0, 0, 0, 0, 7'h00, 13'd16, 11'd4);
    take("R3 wrapped tail", mk(12'h000, 0, 16, 0, 1, 4, 0, 0, RID, 7, CPLID, 0, 0));
  endtask

  task automatic t_back_to_back;
    issue(8'd30, RID, 12'h200, 13'd16);
    drive_cpl(8'd30, RID, 0, 0, 0, 0, 7'h00, 13'd16, 11'd2);
    @(negedge clk);
    drive_cpl(8'd30, RID, 0, 0, 0, 0, 7'h08, 13'd8, 11'd2);
    @(negedge clk); cpl_valid = 0;
    take("R3 b2b first", mk(12'h200, 0, 16, 0, 0, 2, 0, 0, RID, 30, CPLID, 0, 0));
    take("R3 b2b second", mk(12'h208, 0, 8, 0, 1, 2, 0, 0, RID, 30, CPLID, 0, 0));
  endtask

  task automatic t_errors;
    issue(8'd3, RID, 12'h040, 13'd8);
    send(8'd3, RID, 0, 0, 0, 0, 7'h44, 13'd8, 11'd2);
    take("R7 bad address", mk(12'h040, 5, 8, 0, 1, 2, 0, 0, RID, 3, CPLID, 0, 0));
    send(8'd3, RID, 0, 0, 0, 0, 7'h40, 13'd8, 11'd2);
    take("R10 freed after error", mk(12'h040, 6, 8, 0, 0, 2, 0, 0, RID, 3, CPLID, 0, 0));
    issue(8'd4, RID, 12'h080, 13'd8);
    send(8'd4, 16'h0124, 0, 0, 0, 0, 7'h00, 13'd8, 11'd2);
    take("R6 rid mismatch", mk(12'h080, 4, 8, 0, 1, 2, 0, 0, 16'h0124, 4, CPLID, 0, 0));
    issue(8'd6, RID, 12'h0C0, 13'd8);
    send(8'd6, RID, 3'b010, 0, 0, 0, 7'h41, 13'd8, 11'd2);
    take("R9 mismatch over address", mk(12'h0C0, 4, 8, 0, 1, 2, 0, 0, RID, 6, CPLID, 0, 2));
    issue(8'd10, RID, 12'h000, 13'd8);
    send(8'd10, RID, 0, 3'b100, 0, 0, 7'h00, 13'd8, 11'd2);
    take("R4 CA status", mk(12'h000, 2, 8, 0, 1, 2, 4, 0, RID, 10, CPLID, 0, 0));
    issue(8'd11, RID, 12'h000, 13'd8);
    send(8'd11, RID, 0, 3'b001, 1, 0, 7'h00, 13'd8, 11'd2);
    take("R9 poison over status", mk(12'h000, 1, 8, 0, 1, 2, 1, 1, RID, 11, CPLID, 0, 0));
    issue(8'd12, RID, 12'h000, 13'd8);
    send(8'd12, RID, 0, 0, 0, 0, 7'h00, 13'd12, 11'd3);
    take("R5 byte count too big", mk(12'h000, 3, 12, 0, 1, 3, 0, 0, RID, 12, CPLID, 0, 0));
    issue(8'd13, RID, 12'h000, 13'd8);
    send(8'd13, RID, 0, 0, 0, 0, 7'h00, 13'd8, 11'd0);
    take("R5 no data", mk(12'h000, 3, 8, 0, 1, 0, 0, 0, RID, 13, CPLID, 0, 0));
  endtask

  task automatic t_unknown;
    send(8'd200, RID, 0, 0, 0, 0, 7'h15, 13'd4, 11'd1);
    take("R8 unknown tag", mk(12'h015, 6, 4, 0, 0, 1, 0, 0, RID, 200, CPLID, 0, 0));
    send(8'd201, RID, 0, 0, 1, 0, 7'h15, 13'd4, 11'd1);
    take("R9 poison on unknown tag", mk(12'h015, 1, 4, 0, 0, 1, 0, 1, RID, 201, CPLID, 0, 0));
  endtask

  task automatic t_events;
    issue(8'd20, 16'h3456, 12'h010, 13'd8);
    issue(8'd21, 16'h3477, 12'h010, 13'd8);
    ev_valid = 1; ev_kind = 0; ev_tag = 8'd20; @(negedge clk); ev_valid = 0;
    take("R11 timeout", mk(0, 9, 0, 0, 1, 0, 0, 0, 16'h0056, 20, 0, 0, 0));
    ev_valid = 1; ev_kind = 1; ev_tag = 8'd21; @(negedge clk); ev_valid = 0;
    take("R11 function reset", mk(0, 8, 0, 0, 1, 0, 0, 0, 16'h0077, 21, 0, 0, 0));
    send(8'd20, 16'h3456, 0, 0, 0, 0, 7'h10, 13'd8, 11'd2);
    take("R11 freed by event", mk(12'h010, 6, 8, 0, 0, 2, 0, 0, 16'h3456, 20, CPLID, 0, 0));
    ev_valid = 1; ev_kind = 0; ev_tag = 8'd22; @(negedge clk); ev_valid = 0;
    expect_quiet("R11 event on dead tag", 5);
  endtask

  task automatic t_latency;
    drive_cpl(8'd210, RID, 0, 0, 0, 0, 7'h33, 13'd4, 11'd1);
    @(negedge clk); cpl_valid = 0;
    chk("R12 not yet valid", {95'b0, dsc_valid}, 96'b0);
    @(negedge clk);
    chk("R12 valid after two edges", {95'b0, dsc_valid}, 96'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12 held while stalled", dsc_data, mk(12'h033, 6, 4, 0, 0, 1, 0, 0, RID, 210, CPLID, 0, 0));
    end
    take("R12 accepted", mk(12'h033, 6, 4, 0, 0, 1, 0, 0, RID, 210, CPLID, 0, 0));
  endtask

  task automatic t_backpressure;
    for (int i = 1; i <= 6; i++) begin
      drive_cpl(8'd220, RID, 0, 0, 0, 0, 7'(i), 13'd4, 11'd1);
      if (i == 1) begin
        #1;
        chk("R13 event blocked by strobe", {95'b0, ev_ready}, 96'b0);
      end
      @(negedge clk);
    end
    cpl_valid = 0;
    chk("R13 room low when full", {95'b0, cpl_room}, 96'b0);
    for (int i = 1; i <= 4; i++)
      take("R13 queued order", mk(12'(i), 6, 4, 0, 0, 1, 0, 0, RID, 220, CPLID, 0, 0));
    expect_quiet("R13 excess strobes dropped", 4);
  endtask

  initial begin
    rst = 1; iss_valid = 0; iss_tag = 0; iss_rid = 0; iss_tc = 0; iss_attr = 0;
    iss_addr = 0; iss_len = 0; cpl_valid = 0; cpl_tag = 0; cpl_rid = 0; cpl_cplid = 0;
    cpl_tc = 0; cpl_attr = 0; cpl_status = 0; cpl_poison = 0; cpl_locked = 0;
    cpl_laddr = 0; cpl_bcnt = 0; cpl_dwcnt = 0; ev_valid = 0; ev_kind = 0; ev_tag = 0;
    dsc_ready = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_full();
    t_split_wrap();
    t_back_to_back();
    t_errors();
    t_unknown();
    t_events();
    t_latency();
    t_backpressure();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule